// File: doc/BRIEF.md
# Rate-Bounded Activation Stream Generator

The block emits an activation bit stream whose running count of ones stays inside a band between two parallel lines. The lines share the slope `rate_num / rate_den`. Their offsets are `shift_lo / rate_den` for the lower line and `shift_hi / rate_den` for the upper line. All fractions therefore use the rate denominator as their common denominator, so every test is an integer comparison with no division.

The block keeps an instant index `i` and a count `j` of ones already emitted. On each enabled cycle it decides whether a one and whether a zero is permitted at the current point. It then picks the bit using one of three policies: eager (a one whenever one is allowed), lazy (a zero whenever one is allowed), or a bit supplied from outside that the block validates. After each emitted bit the state is folded back by one period whenever both counters have reached it, so the counters stay small.

A typical use is to produce a worst-case early or worst-case late schedule from an abstract rate-and-jitter description. The external mode checks a candidate activation word against the same description.

Top module: `abs_clock_gen`

## Requirements
- R1: Reset behaviour.
  - While the synchronised reset is active, `clk_bit` is 0.
  - Reset places the state at `i = 1`, `j = 0`. The first enabled step after reset is therefore decided at that point.
- R2: `one_ok` is 1 exactly when `j*rate_den <= rate_num*i + shift_hi`, using signed arithmetic.
- R3: `zero_ok` is 1 exactly when `j*rate_den >= rate_num*i + shift_lo`, using signed arithmetic.
- R4: State update after an emitted bit `b`.
  - The new state is `i+1` and `j+b`.
  - If the new `i` is at least `rate_den` and the new `j` is at least `rate_num`, then `rate_den` is subtracted from `i` and `rate_num` from `j`.
- R5: Eager policy, `mode` = 2'b00. The emitted bit is 1 when `one_ok` is 1, otherwise 0.
- R6: Lazy policy, `mode` = 2'b01. The emitted bit is 0 when `zero_ok` is 1, otherwise 1.
- R7: External policy, `mode[1]` = 1. When `ext_bit` is permitted, it is emitted unchanged on `clk_bit` and the state advances.
- R8: In external policy, when `ext_bit` is not permitted but some bit is:
  - `violation` is 1 for that cycle;
  - `clk_bit` is 0;
  - the state does not change.
- R9: When neither bit is permitted and `en` is 1:
  - `stuck_err` is 1;
  - `violation` is 0;
  - `clk_bit` is 0;
  - the state does not change.
- R10: When `en` is 0, `clk_bit`, `stuck_err` and `violation` are all 0 and the state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Step enable for the current cycle |
| mode | input | 2 | Policy: 00 eager, 01 lazy, 1x external |
| ext_bit | input | 1 | Candidate bit in external policy |
| rate_num | input | CW | Slope numerator |
| rate_den | input | CW | Slope denominator and common denominator of the shifts |
| shift_lo | input | SW | Signed numerator of the lower line offset |
| shift_hi | input | SW | Signed numerator of the upper line offset |
| clk_bit | output | 1 | Emitted activation bit (0 when no step is taken) |
| one_ok | output | 1 | A one is permitted at the current state |
| zero_ok | output | 1 | A zero is permitted at the current state |
| stuck_err | output | 1 | Neither bit is permitted; the step is refused |
| violation | output | 1 | The external bit was refused |

## Verification
Every cycle, the assertions check the following:
- An emitted one always had `one_ok` set, and an emitted zero always had `zero_ok` set.
- The eager and lazy policies pick the bit the rules require.
- An external bit, once accepted, is passed through unchanged.
- At most one of step, stuck and violation occurs in a cycle.
- The state holds whenever no step is taken.

The exact envelope arithmetic cannot be checked by these properties: the signed products, the period folding and the reset point of (1, 0). These are shown only by the bench's scenarios. The bench compares every output, cycle by cycle, against an independent model of the state. Its stimulus covers random rates, shifts, policies and enables, and also a one-third rate with one instant of jitter and an inconsistent band.

// File: rtl/abs_clock_pkg.sv
package abs_clock_pkg;
  typedef enum logic [1:0] {
    POL_EAGER = 2'b00,
    POL_LAZY  = 2'b01,
    POL_EXT   = 2'b10,
    POL_EXT2  = 2'b11
  } policy_e;
endpackage

// File: rtl/envelope_cmp.sv
module envelope_cmp #(
  parameter int I_W = 16,
  parameter int CW  = 8,
  parameter int SW  = 12
) (
  input  logic [I_W-1:0]       idx,
  input  logic [I_W-1:0]       cnt,
  input  logic [CW-1:0]        rate_num,
  input  logic [CW-1:0]        rate_den,
  input  logic signed [SW-1:0] shift_lo,
  input  logic signed [SW-1:0] shift_hi,
  output logic                 one_ok,
  output logic                 zero_ok
);
  localparam int PW = I_W + CW + 2;

  logic signed [PW-1:0] scaled_cnt;
  logic signed [PW-1:0] line_base;
  logic signed [PW-1:0] upper_line;
  logic signed [PW-1:0] lower_line;

  always_comb begin
    scaled_cnt = signed'(PW'(cnt)) * signed'(PW'(rate_den));
    line_base  = signed'(PW'(rate_num)) * signed'(PW'(idx));
    upper_line = line_base + PW'(shift_hi);
    lower_line = line_base + PW'(shift_lo);
    one_ok     = (scaled_cnt <= upper_line);
    zero_ok    = (scaled_cnt >= lower_line);
  end
endmodule

// File: rtl/choice_sel.sv
module choice_sel
  import abs_clock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       ext_bit,
  input  logic       one_ok,
  input  logic       zero_ok,
  output logic       fire,
  output logic       bit_sel,
  output logic       stuck,
  output logic       viol
);
  policy_e pol;
  logic    ext_ok;

  always_comb begin
    pol     = policy_e'(mode);
    stuck   = en && !one_ok && !zero_ok;
    ext_ok  = ext_bit ? one_ok : zero_ok;
    viol    = 1'b0;
    bit_sel = 1'b0;
    unique case (pol)
      POL_EAGER: bit_sel = one_ok;
      POL_LAZY:  bit_sel = !zero_ok;
      default: begin
        bit_sel = ext_bit;
        viol    = en && !stuck && !ext_ok;
      end
    endcase
    fire = en && !stuck && !viol && rst_n;
  end

  p_eager_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == 2'b00) |-> (bit_sel == one_ok));
  p_lazy_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == 2'b01) |-> (bit_sel == !zero_ok));
  p_ext_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode[1]) |-> (bit_sel == ext_bit));
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire, stuck, viol}));
endmodule

// File: rtl/state_reg.sv
module state_reg #(
  parameter int I_W = 16,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           bit_in,
  input  logic [CW-1:0]  rate_num,
  input  logic [CW-1:0]  rate_den,
  output logic [I_W-1:0] idx_q,
  output logic [I_W-1:0] cnt_q
);
  logic [I_W-1:0] idx_inc, cnt_inc;
  logic [I_W-1:0] idx_d, cnt_d;
  logic           fold;

  always_comb begin
    idx_inc = idx_q + I_W'(1);
    cnt_inc = cnt_q + I_W'(bit_in);
    fold    = (idx_inc >= I_W'(rate_den)) && (cnt_inc >= I_W'(rate_num));
    idx_d   = fold ? (idx_inc - I_W'(rate_den)) : idx_inc;
    cnt_d   = fold ? (cnt_inc - I_W'(rate_num)) : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= I_W'(1);
      cnt_q <= '0;
    end else if (fire) begin
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(idx_q) && $stable(cnt_q)));
endmodule

// File: rtl/abs_clock_gen.sv
module abs_clock_gen #(
  parameter int I_W = 16,
  parameter int CW  = 8,
  parameter int SW  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [1:0]           mode,
  input  logic                 ext_bit,
  input  logic [CW-1:0]        rate_num,
  input  logic [CW-1:0]        rate_den,
  input  logic signed [SW-1:0] shift_lo,
  input  logic signed [SW-1:0] shift_hi,
  output logic                 clk_bit,
  output logic                 one_ok,
  output logic                 zero_ok,
  output logic                 stuck_err,
  output logic                 violation
);
  logic [1:0]     rst_pipe;
  logic           rst_int_n;
  logic [I_W-1:0] idx, cnt;
  logic           fire, bit_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  envelope_cmp #(.I_W(I_W), .CW(CW), .SW(SW)) u_env (
    .idx(idx), .cnt(cnt), .rate_num(rate_num), .rate_den(rate_den),
    .shift_lo(shift_lo), .shift_hi(shift_hi),
    .one_ok(one_ok), .zero_ok(zero_ok)
  );

  choice_sel u_sel (
    .clk(clk), .rst_n(rst_int_n), .en(en), .mode(mode), .ext_bit(ext_bit),
    .one_ok(one_ok), .zero_ok(zero_ok),
    .fire(fire), .bit_sel(bit_sel), .stuck(stuck_err), .viol(violation)
  );

  state_reg #(.I_W(I_W), .CW(CW)) u_state (
    .clk(clk), .rst_n(rst_int_n), .fire(fire), .bit_in(bit_sel),
    .rate_num(rate_num), .rate_den(rate_den),
    .idx_q(idx), .cnt_q(cnt)
  );

  assign clk_bit = fire && bit_sel;

  p_one_legal_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fire && bit_sel) |-> one_ok);
  p_zero_legal_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fire && !bit_sel) |-> zero_ok);
  p_refused_quiet_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (violation || stuck_err) |-> !clk_bit);
endmodule

// File: tb/abs_clock_gen_tb.sv
module abs_clock_gen_tb;
  localparam int I_W = 16;
  localparam int CW  = 8;
  localparam int SW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ext_bit = 1'b0;
  logic [CW-1:0] rate_num = 8'd1;
  logic [CW-1:0] rate_den = 8'd3;
  logic signed [SW-1:0] shift_lo = -12'sd1;
  logic signed [SW-1:0] shift_hi = 12'sd1;
  logic clk_bit, one_ok, zero_ok, stuck_err, violation;

  int checks = 0;
  int errors = 0;
  int mi, mj;
  bit finished = 0;

  always #2 clk = ~clk;

  abs_clock_gen #(.I_W(I_W), .CW(CW), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .ext_bit(ext_bit),
    .rate_num(rate_num), .rate_den(rate_den),
    .shift_lo(shift_lo), .shift_hi(shift_hi),
    .clk_bit(clk_bit), .one_ok(one_ok), .zero_ok(zero_ok),
    .stuck_err(stuck_err), .violation(violation)
  );

  function automatic bit f_one(int i, int j);
    return j * int'(rate_den) <= int'(rate_num) * i + int'(shift_hi);
  endfunction
  function automatic bit f_zero(int i, int j);
    return j * int'(rate_den) >= int'(rate_num) * i + int'(shift_lo);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one enabled or idle cycle; checks outputs then advances the model
  task automatic cyc(input logic e, input logic [1:0] m, input logic x);
    bit o1, o0, st, vi, fi, b;
    string rq;
    @(negedge clk);
    en = e; mode = m; ext_bit = x;
    #1;
    o1 = f_one(mi, mj);
    o0 = f_zero(mi, mj);
    st = e && !o1 && !o0;
    vi = e && m[1] && !st && !(x ? o1 : o0);
    fi = e && !st && !vi;
    if (m == 2'b00)      begin b = o1;  rq = "R5"; end
    else if (m == 2'b01) begin b = !o0; rq = "R6"; end
    else                 begin b = x;   rq = "R7"; end
    if (!e) rq = "R10";
    chk("R2", "one_ok", one_ok, o1);
    chk("R3", "zero_ok", zero_ok, o0);
    chk("R9", "stuck_err", stuck_err, st);
    chk("R8", "violation", violation, vi);
    chk(rq, "clk_bit", clk_bit, fi && b);
    if (fi) begin
      int ni, nj;
      ni = mi + 1;
      nj = mj + int'(b);
      if (ni >= int'(rate_den) && nj >= int'(rate_num)) begin
        ni -= int'(rate_den);
        nj -= int'(rate_num);
      end
      mi = ni; mj = nj;   // R4 folding model
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b1; mode = 2'b00;
    #1;
    chk("R1", "clk_bit in reset", clk_bit, 0);
    @(negedge clk);
    rst_n = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    mi = 1; mj = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    mi = 1; mj = 0;
    repeat (2) @(negedge clk);
    do_reset();
    // R1: first decision at (1,0): one third rate, jitter one instant
    #1;
    chk("R1", "one_ok at reset point", one_ok, 1);
    chk("R1", "zero_ok at reset point", zero_ok, 1);
    // R5: eager on rate 1/3, shifts -1/3 .. 1/3 -> 1,1,0,0,1,0,0,1
    for (int k = 0; k < 12; k++) cyc(1'b1, 2'b00, 1'b0);
    // R10: idle cycles hold the state
    for (int k = 0; k < 4; k++) cyc(1'b0, 2'b00, 1'b1);
    // R6: lazy policy on the same band
    do_reset();
    for (int k = 0; k < 12; k++) cyc(1'b1, 2'b01, 1'b0);
    // R7/R8: external word, with refused bits mixed in
    do_reset();
    for (int k = 0; k < 16; k++) cyc(1'b1, 2'b10, (k % 2) == 0);
    for (int k = 0; k < 8; k++)  cyc(1'b1, 2'b11, 1'b1);
    // R9: inconsistent band, lower line above upper line
    shift_lo = 12'sd5; shift_hi = -12'sd5;
    do_reset();
    for (int k = 0; k < 4; k++) cyc(1'b1, 2'b00, 1'b0);
    for (int k = 0; k < 4; k++) cyc(1'b1, 2'b10, 1'b1);
    // random phases
    for (int p = 0; p < 40; p++) begin
      int den, num, lo, hi;
      den = 1 + int'($urandom_range(6));
      num = int'($urandom_range(den));
      lo  = -int'($urandom_range(2 * den));
      hi  = lo + int'($urandom_range(3 * den)) - ((p % 9 == 0) ? 2 : 0);
      rate_den = CW'(den); rate_num = CW'(num);
      shift_lo = SW'(lo);  shift_hi = SW'(hi);
      do_reset();
      for (int k = 0; k < 200; k++)
        cyc($urandom_range(7) != 0, 2'($urandom_range(3)), 1'($urandom_range(1)));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule